// File: doc/BRIEF.md
# I2C Byte Capture With Travelling Marker

This block turns the serial bit stream of an I2C bus into parallel words for a logic analyzer. Each transfer of eight data bits plus the acknowledge bit lands in a ten-position shift chain. The chain is armed with a single marker bit. Each rising edge of the I2C clock line shifts the data line into the low end of the chain, which pushes the marker one position up. The byte is complete when the marker reaches the top position. A bit counter is not used for this framing.

When the marker arrives, an internal tag goes high. The data byte and the acknowledge bit are then copied into an output register. A delay sequencer runs on a slow delay-clock enable. It produces a store strobe for the analyzer, which should sample on the strobe's falling edge. A fixed number of delay ticks after the tag, the sequencer re-arms the chain without any extra I2C clock edge. A start-detected pulse from an external start detector re-arms the chain at once, even in the middle of a byte or during the strobe sequence.

Top module: `i2c_byte_capture`

## Requirements
- R1: After reset the chain is armed, with the marker in position 0 and every other position 0. The tag, the store strobe, the data output and the ack output are all 0.
- R2: A rising edge of `scl_i` is a sample at 1 that follows a sample at 0 on the previous clock. Each such edge shifts `sda_i` into chain position 0, so the first bit of a transfer is the most significant bit of the byte.
- R3: A high `start_i` re-arms the chain at the next clock edge. It takes priority over any shift and over any tag. It also cancels a pending strobe or re-arm.
- R4: `tag_o` stays low after eight shifts from the armed state. It goes high at the clock edge of the ninth shift.
- R5: One clock after `tag_o` rises, `data_o` holds the eight bits that were shifted in first, with the first bit in bit 7. `ack_o` holds the ninth bit, where 0 means acknowledged and 1 means not acknowledged.
- R6: `store_o` goes high at the first `tick_i` clock after the tag rises and falls at the second. It therefore lasts exactly one tick period. `data_o` and `ack_o` are valid at its falling edge.
- R7: At the third `tick_i` clock after the tag rises, the chain is re-armed and `tag_o` drops, with no `scl_i` edge needed. With `tick_i` held high, the tag stays high for 3 clocks.
- R8: `scl_i` rising edges that arrive while `tag_o` is high are ignored. They change neither the chain nor the outputs.
- R9: While `tick_i` is low, the delay sequence does not advance and `store_o` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_i | input | 1 | I2C data line, already synchronised |
| scl_i | input | 1 | I2C clock line, already synchronised |
| start_i | input | 1 | One-clock pulse from the start detector |
| tick_i | input | 1 | Delay-clock enable |
| data_o | output | 8 | Captured data byte |
| ack_o | output | 1 | Captured ninth bit (0 ACK, 1 NACK) |
| store_o | output | 1 | Store strobe to the analyzer |
| tag_o | output | 1 | Marker has reached the last position |

## Verification
All 256 byte values are sent, each with an acknowledge bit that depends on the byte. This shows that every bit lands in its own output position and that the ninth bit is kept apart from the data. A transfer is also checked after eight bits, which separates a correct ninth-edge tag from an early or late one. Start pulses are sent in the middle of a byte and in the middle of a strobe sequence, which shows that arming overrides both the shifting and the pending strobe. Extra clock edges are sent while the delay clock is stopped, followed by a transfer with no start pulse. This shows that edges during the tag are ignored and that the re-arm does not depend on any further edge. A run with a slow delay clock shows that the strobe width follows the tick period and not the system clock.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;
  // chain length for a given data width: data bits, ack bit, marker slot
  function automatic int unsigned chain_len(input int unsigned dw);
    return dw + 2;
  endfunction

  // counter width needed to count up to a tick limit
  function automatic int unsigned cnt_bits(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // store strobe window, in ticks counted since the tag rose
  function automatic logic in_window(input int unsigned c,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (c >= lo) && (c < hi);
  endfunction
endpackage

// File: rtl/i2cbc_edge.sv
module i2cbc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic rise_o
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
endmodule

// File: rtl/i2cbc_chain.sv
module i2cbc_chain #(
  parameter int unsigned LEN = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm_i,
  input  logic           shift_i,
  input  logic           bit_i,
  output logic [LEN-1:0] chain_o
);
  localparam logic [LEN-1:0] ARMED = {{(LEN-1){1'b0}}, 1'b1};

  logic full;
  assign full = chain_o[LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n)                chain_o <= ARMED;
    else if (arm_i)            chain_o <= ARMED;
    else if (shift_i && !full) chain_o <= {chain_o[LEN-2:0], bit_i};
  end
endmodule

// File: rtl/i2cbc_seq.sv
module i2cbc_seq #(
  parameter int unsigned STROBE_LO = 1,
  parameter int unsigned STROBE_HI = 2,
  parameter int unsigned REARM_AT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_i,
  input  logic tick_i,
  input  logic start_i,
  output logic load_o,
  output logic strobe_o,
  output logic rearm_o
);
  import i2cbc_pkg::*;
  localparam int unsigned CW = cnt_bits(REARM_AT);
  localparam logic [CW-1:0] LAST = CW'(REARM_AT - 1);

  logic [CW-1:0] cnt;
  logic          tag_q;

  assign rearm_o  = tag_i && tick_i && !start_i && (cnt == LAST);
  assign load_o   = tag_i && !tag_q;
  assign strobe_o = tag_i && in_window(32'(cnt), STROBE_LO, STROBE_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tag_q <= 1'b0;
    end else begin
      tag_q <= tag_i && !start_i;
      if (start_i || !tag_i || rearm_o) cnt <= '0;
      else if (tick_i)                  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_byte_capture.sv
module i2c_byte_capture #(
  parameter int unsigned DW        = 8,
  parameter int unsigned STROBE_LO = 1,
  parameter int unsigned STROBE_HI = 2,
  parameter int unsigned REARM_AT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_i,
  input  logic          scl_i,
  input  logic          start_i,
  input  logic          tick_i,
  output logic [DW-1:0] data_o,
  output logic          ack_o,
  output logic          store_o,
  output logic          tag_o
);
  import i2cbc_pkg::*;
  localparam int unsigned LEN = chain_len(DW);
  localparam logic [LEN-1:0] ARMED = {{(LEN-1){1'b0}}, 1'b1};

  logic           scl_rise;
  logic           load;
  logic           rearm;
  logic [LEN-1:0] chain;

  i2cbc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .rise_o(scl_rise)
  );

  i2cbc_chain #(.LEN(LEN)) u_chain (
    .clk(clk), .rst_n(rst_n), .arm_i(start_i | rearm),
    .shift_i(scl_rise), .bit_i(sda_i), .chain_o(chain)
  );

  assign tag_o = chain[LEN-1];

  i2cbc_seq #(.STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI),
              .REARM_AT(REARM_AT)) u_seq (
    .clk(clk), .rst_n(rst_n), .tag_i(tag_o), .tick_i(tick_i),
    .start_i(start_i), .load_o(load), .strobe_o(store_o), .rearm_o(rearm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      ack_o  <= 1'b0;
    end else if (load) begin
      data_o <= chain[DW:1];
      ack_o  <= chain[0];
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (chain == ARMED)); // R3
  AST_EDGES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_o && !start_i && !rearm) |=> $stable(chain)); // R8
  AST_REARM_DROPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !start_i) |=> (!tag_o && chain == ARMED)); // R7
  AST_LOAD_ON_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_o) |=> (data_o == $past(chain[DW:1]) && ack_o == $past(chain[0]))); // R5
  AST_STROBE_AFTER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> $past(tag_o)); // R6
  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_o && !tick_i && !start_i) |=> $stable(store_o)); // R9
endmodule

// File: tb/test_i2c_byte_capture.sv
`timescale 1ns/1ps
module test_i2c_byte_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sda = 1'b0, scl = 1'b0, start = 1'b0, tick = 1'b0;
  logic [7:0] data;
  logic       ack, store, tag;

  int checks = 0, fails = 0;
  int tick_period = 1;
  int cyc = 0;
  int caps = 0;
  logic [7:0] cap_data;
  logic       cap_ack;
  int s_run = 0, s_width = 0, t_run = 0, t_width = 0;
  logic s_prev = 1'b0, t_prev = 1'b0;

  always #2 clk = ~clk;

  i2c_byte_capture i_i2c_byte_capture (
    .clk(clk), .rst_n(rst_n), .sda_i(sda), .scl_i(scl), .start_i(start),
    .tick_i(tick), .data_o(data), .ack_o(ack), .store_o(store), .tag_o(tag)
  );

  // delay-clock enable and output monitor, all on the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= (tick_period > 0) && ((cyc % (tick_period > 0 ? tick_period : 1)) == 0);
    if (s_prev && !store) begin
      caps <= caps + 1;
      cap_data <= data;
      cap_ack <= ack;
      s_width <= s_run;
    end
    s_run <= store ? s_run + 1 : 0;
    if (t_prev && !tag) t_width <= t_run;
    t_run <= tag ? t_run + 1 : 0;
    s_prev <= store;
    t_prev <= tag;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    sda = b; scl = 1'b1; @(negedge clk);
    scl = 1'b0; @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && tag; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic a);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(a);
  endtask

  task automatic frame(input logic [7:0] b, input logic a);
    pulse_start();
    send_byte(b, a);
    wait_idle();
  endtask

  initial begin
    int ecaps;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(data == 8'h00, "R1 data", data, 0);
    check(ack == 1'b0, "R1 ack", ack, 0);
    check(store == 1'b0, "R1 strobe", store, 0);
    check(tag == 1'b0, "R1 tag", tag, 0);

    // R4 tag on the ninth edge only
    pulse_start();
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    check(tag == 1'b0, "R4 after eight", tag, 0);
    send_bit(1'b1);
    check(tag == 1'b1, "R4 after nine", tag, 1);
    wait_idle();
    ecaps = caps;

    // R2 R5 R6 R7 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic a;
      b = 8'(v);
      a = b[0] ^ b[7];
      frame(b, a);
      ecaps++;
      check(caps == ecaps, "R6 one strobe", caps, ecaps);
      check(cap_data == b, "R2 R5 data", cap_data, b);
      check(cap_ack == a, "R5 ack", cap_ack, a);
      check(s_width == 1, "R6 strobe width", s_width, 1);
      check(t_width == 3, "R7 tag width", t_width, 3);
    end

    // R3 start in the middle of a byte
    pulse_start();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    frame(8'h0F, 1'b0);
    ecaps++;
    check(caps == ecaps && cap_data == 8'h0F, "R3 mid-byte start", cap_data, 8'h0F);

    // R8 R9 edges while tag high, delay clock stopped
    tick_period = 0;
    repeat (2) @(negedge clk);
    pulse_start();
    send_byte(8'hA5, 1'b1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    repeat (10) @(negedge clk);
    check(tag == 1'b1, "R9 tag held", tag, 1);
    check(store == 1'b0, "R9 no strobe", store, 0);
    check(data == 8'hA5 && ack == 1'b1, "R8 outputs", data, 8'hA5);
    tick_period = 1;
    wait_idle();
    ecaps++;
    check(caps == ecaps && cap_data == 8'hA5, "R8 capture", cap_data, 8'hA5);
    // R7 re-armed without extra edge: next byte with no start
    send_byte(8'h3C, 1'b0);
    wait_idle();
    ecaps++;
    check(caps == ecaps && cap_data == 8'h3C, "R7 R8 no-start byte", cap_data, 8'h3C);

    // R3 start cancels a pending strobe
    tick_period = 0;
    repeat (2) @(negedge clk);
    pulse_start();
    send_byte(8'h81, 1'b0);
    pulse_start();
    @(negedge clk);
    check(tag == 1'b0, "R3 tag cleared", tag, 0);
    tick_period = 1;
    repeat (10) @(negedge clk);
    check(caps == ecaps, "R3 strobe cancelled", caps, ecaps);
    frame(8'h42, 1'b1);
    ecaps++;
    check(caps == ecaps && cap_data == 8'h42, "R3 after cancel", cap_data, 8'h42);

    // R6 strobe spans one slow tick period
    tick_period = 4;
    frame(8'hC3, 1'b0);
    ecaps++;
    check(caps == ecaps && cap_data == 8'hC3, "R6 slow data", cap_data, 8'hC3);
    check(s_width == 4, "R6 slow width", s_width, 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule